// File: doc/BRIEF.md
# Full-Speed End-of-Packet Detector

This block watches an oversampled full-speed bus line and reports each valid end-of-packet. It runs on the 48 MHz clock, which gives four samples per 12 MHz bit time. Its inputs are a single-ended-zero flag and a J-state flag, both already synchronized to that clock. Its only output is a one-cycle strobe that the packet state machines in the bit-rate domain consume.

A run of single-ended-zero samples counts only when it is long enough. It must last at least `MIN_SE0` consecutive samples, which is about 83 ns at the default of 4. Shorter runs are treated as glitches and dropped. A qualifying run must then be closed by a J sample.

The two line flags reach the block with independent skew. For that reason a short grace window of up to `DEAD_MAX` samples is allowed between the end of the single-ended zero and the J. During that window the line may read as neither state. The width counter saturates, so a very long single-ended zero, such as a bus reset, still counts as qualified.

Top module: `se0_eop_detect`

## Requirements
- R1: `eop_o` is 0 while `rst_n` is low, and it stays 0 after reset until an end-of-packet has been detected.
- R2: A run of 4 or more consecutive samples with `se0_i`=1, followed directly by a sample with `se0_i`=0 and `j_i`=1, makes `eop_o` 1 in the clock cycle after the edge that sampled the J. Here 4 is the default `MIN_SE0`.
- R3: A run of 1, 2 or 3 samples with `se0_i`=1, followed by J, never raises `eop_o`.
- R4: After a qualifying run, 1 or 2 samples with `se0_i`=0 and `j_i`=0 are tolerated, and a J sample that follows them still produces the strobe.
- R5: After a qualifying run, a 3rd consecutive sample with neither flag abandons the candidate, and a later J produces no strobe.
- R6: When `se0_i` returns to 1 during the grace window, width qualification starts again from zero, so the new run must itself reach 4 samples before J produces a strobe.
- R7: The width count saturates instead of wrapping. A run of 50 samples with `se0_i`=1, followed by J, produces the strobe.
- R8: `eop_o` is a registered pulse and is never 1 in two consecutive cycles.
- R9: J samples with no preceding qualifying run produce no strobe. A sample with both `se0_i`=1 and `j_i`=1 counts as single-ended zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| se0_i | input | 1 | Synchronized single-ended-zero flag |
| j_i | input | 1 | Synchronized J-state flag |
| eop_o | output | 1 | One-cycle end-of-packet strobe |

## Verification
The stimulus sweeps the single-ended-zero width through 1, 2, 3, 4, 5 and 50 samples, each closed by J. This separates glitch rejection from acceptance and shows that the count saturates rather than wrapping.

Grace windows of 1, 2 and 3 neither-state samples locate the exact point at which a candidate is abandoned. A return to single-ended zero inside the window is tried with a second run that is too short and with one that is long enough, which shows that qualification restarts.

Lone J traffic and samples with both flags set show that the strobe needs a true single-ended-zero history. The sample after every strobe confirms that the pulse lasts a single cycle.

// File: rtl/eop_pkg.sv
package eop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DEAD  = 2'd2
  } eop_state_e;

  // Saturating increment: stops at the ceiling instead of wrapping.
  function automatic int sat_inc(input int value, input int ceiling);
    return (value >= ceiling) ? ceiling : value + 1;
  endfunction

  // A single-ended-zero run is long enough once it reaches the minimum.
  function automatic logic width_ok(input int run, input int min_run);
    return run >= min_run;
  endfunction

endpackage

// File: rtl/eop_se0_counter.sv
module eop_se0_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             se0_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;

  // Counts consecutive single-ended-zero samples; any other sample clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (se0_i) cnt_q <= CNT_W'(eop_pkg::sat_inc(int'(cnt_q), CNT_MAX));
    else            cnt_q <= '0;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/eop_fsm.sv
module eop_fsm
  import eop_pkg::*;
#(
  parameter int MIN_SE0  = 4,
  parameter int DEAD_MAX = 2,
  parameter int CNT_W    = 4,
  parameter int DEAD_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              se0_i,
  input  logic              j_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output eop_state_e        state_o,
  output logic [DEAD_W-1:0] dead_o,
  output logic              fire_o
);
  eop_state_e        state_q, state_d;
  logic [DEAD_W-1:0] dead_q, dead_d;
  logic              qualified;

  assign qualified = width_ok(int'(cnt_i), MIN_SE0);

  always_comb begin
    state_d = state_q;
    dead_d  = '0;
    fire_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (se0_i) state_d = ST_COUNT;
      end
      ST_COUNT: begin
        if (!se0_i) begin
          if (!qualified) begin
            state_d = ST_IDLE;
          end else if (j_i) begin
            fire_o  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_DEAD;
            dead_d  = DEAD_W'(1);
          end
        end
      end
      ST_DEAD: begin
        if (se0_i) begin
          state_d = ST_COUNT;
        end else if (j_i) begin
          fire_o  = 1'b1;
          state_d = ST_IDLE;
        end else if (int'(dead_q) >= DEAD_MAX) begin
          state_d = ST_IDLE;
        end else begin
          dead_d  = dead_q + DEAD_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dead_q  <= '0;
    end else begin
      state_q <= state_d;
      dead_q  <= dead_d;
    end
  end

  assign state_o = state_q;
  assign dead_o  = dead_q;
endmodule

// File: rtl/eop_pulse_reg.sv
module eop_pulse_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= fire_i;
  end
endmodule

// File: rtl/se0_eop_detect.sv
module se0_eop_detect #(
  parameter int MIN_SE0  = 4,
  parameter int DEAD_MAX = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0_i,
  input  logic j_i,
  output logic eop_o
);
  localparam int CNT_W  = $clog2(MIN_SE0 + 1) + 1;
  localparam int DEAD_W = $clog2(DEAD_MAX + 1);

  eop_pkg::eop_state_e state_w;
  logic [CNT_W-1:0]    cnt_w;
  logic [DEAD_W-1:0]   dead_w;
  logic                fire_w;

  eop_se0_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .se0_i(se0_i), .cnt_o(cnt_w)
  );

  eop_fsm #(
    .MIN_SE0(MIN_SE0), .DEAD_MAX(DEAD_MAX), .CNT_W(CNT_W), .DEAD_W(DEAD_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .se0_i(se0_i), .j_i(j_i), .cnt_i(cnt_w),
    .state_o(state_w), .dead_o(dead_w), .fire_o(fire_w)
  );

  eop_pulse_reg u_pulse (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_w), .pulse_o(eop_o)
  );
endmodule

// File: rtl/eop_detect_checker.sv
module eop_detect_checker
  import eop_pkg::*;
#(
  parameter int MIN_SE0  = 4,
  parameter int DEAD_MAX = 2,
  parameter int CNT_W    = 4,
  parameter int DEAD_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              se0_i,
  input logic              j_i,
  input logic              eop_o,
  input eop_state_e        state_w,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [DEAD_W-1:0] dead_w
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!eop_o);
  end

  assert_eop_after_j_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |-> ($past(j_i) && !$past(se0_i)));

  assert_short_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_COUNT && !se0_i && int'(cnt_w) < MIN_SE0) |=> (state_w == ST_IDLE && !eop_o));

  assert_dead_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dead_w) <= DEAD_MAX);

  assert_abandon_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_DEAD && int'(dead_w) >= DEAD_MAX && !se0_i && !j_i) |=> (state_w == ST_IDLE));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_w == CNT_TOP && se0_i) |=> (cnt_w == CNT_TOP));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |=> !eop_o);
endmodule

bind se0_eop_detect eop_detect_checker #(
  .MIN_SE0(MIN_SE0), .DEAD_MAX(DEAD_MAX), .CNT_W(CNT_W), .DEAD_W(DEAD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .se0_i(se0_i), .j_i(j_i), .eop_o(eop_o),
  .state_w(state_w), .cnt_w(cnt_w), .dead_w(dead_w)
);

// File: tb/sim_se0_eop_detect.sv
module sim_se0_eop_detect;
  localparam int CLK_PERIOD = 20;
  localparam int MIN_RUN    = 4;
  localparam int GRACE      = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic se0 = 1'b0;
  logic j = 1'b1;
  logic eop;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  se0_eop_detect u0 (.clk(clk), .rst_n(rst_n), .se0_i(se0), .j_i(j), .eop_o(eop));

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  // Driver: apply one sample and queue the eop value expected after its edge.
  task automatic step(input bit s, input bit jj, input bit exp, input string tag);
    @(negedge clk);
    se0 = s;
    j   = jj;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Single-ended-zero run, grace samples, then an optional J and idle tail.
  task automatic frame(input int n_se0, input int n_mid, input bit end_j, input string tag);
    for (int i = 0; i < n_se0; i++) step(1'b1, 1'b0, 1'b0, tag);
    for (int i = 0; i < n_mid; i++) step(1'b0, 1'b0, 1'b0, tag);
    if (end_j) step(1'b0, 1'b1, (n_se0 >= MIN_RUN) && (n_mid <= GRACE), tag);
    step(1'b0, 1'b1, 1'b0, {tag, "/R8"});
    step(1'b0, 1'b1, 1'b0, tag);
  endtask

  // Monitor: compare each queued expectation just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (eop !== e) begin
          n_fails++;
          $display("FAIL %s: eop_o=%0b expected %0b", t, eop, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (eop !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: eop_o=%0b in reset expected 0", eop);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, "R1");

    frame(4, 0, 1'b1, "R2");
    frame(5, 0, 1'b1, "R2");
    frame(1, 0, 1'b1, "R3");
    frame(2, 0, 1'b1, "R3");
    frame(3, 0, 1'b1, "R3");
    frame(4, 1, 1'b1, "R4");
    frame(6, 2, 1'b1, "R4");
    frame(4, 3, 1'b1, "R5");
    frame(5, 4, 1'b0, "R5");

    // R6: re-entry from grace window restarts qualification.
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b0, "R6");
    frame(2, 0, 1'b1, "R6");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b0, "R6");
    frame(4, 0, 1'b1, "R6");

    frame(50, 0, 1'b1, "R7");
    frame(17, 1, 1'b1, "R7");

    // R9: lone J and both-flag samples.
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b1, "R9");
    step(1'b0, 1'b1, 1'b0, "R9/R8");

    repeat (4) @(negedge clk);
    report();
  end
endmodule